// File: doc/BRIEF.md
# Guarded SPI Command Master

This block is the host side of a command link to a slow peripheral whose SPI port is serviced by firmware. One request carries an opcode, a count of write bytes, a count of padding bytes, a count of read bytes and the write bytes themselves. The block frames the whole exchange under one chip-select window. It sends the opcode first, then the write bytes, then all-zero filler bytes while the peripheral pads and returns its answer. It hands the captured read bytes back with a one-cycle completion strobe.

Because the far end needs time to react, every edge of the exchange is padded. Chip select leads the first clock by a settle interval. Bytes are separated by a gap, chip select is held after the last clock, and it stays high for a recovery interval before another request is accepted. All these intervals and the SCK half period are counted in system-clock cycles, set by parameters. With the defaults and a 50 MHz system clock, they meet a 125 kHz SCK limit and 65/40/100/50 µs guards.

Top module: `spi_guard_master`

## Requirements
- R1: While reset is held and afterwards until a request arrives, `nss_o` is 1, `sck_o` is 0, `busy_o` and `done_o` are 0 and `rd_data_o` is all zero.
- R2: SPI mode 0: SCK idles low, and MOSI holds one value for the whole low and high phase of a bit, changing only while SCK is low. Bytes go most significant bit first.
- R3: SCK is low for exactly HALF_DIV cycles before each rise and high for exactly HALF_DIV cycles.
- R4: A request accepted in a cycle drives `nss_o` low from the next cycle. The first bit's low phase starts LEAD_CYC cycles later, so NSS-fall to first SCK rise is LEAD_CYC+HALF_DIV cycles.
- R5: Between the falling SCK edge ending one byte and the low phase of the next byte, SCK stays low for exactly GAP_CYC extra cycles.
- R6: After the last byte's final SCK fall, `nss_o` stays low for exactly TRAIL_CYC cycles, then rises.
- R7: After `nss_o` rises it stays high with `busy_o` still 1 for IDLE_CYC cycles. During every cycle with `busy_o` = 1 a request is refused: `ack_o` is 0 and no new exchange starts.
- R8: The transaction has 1+wr+pad+rd bytes. MOSI carries the opcode, then write byte k taken from `req_wr_data_i[8k+7:8k]` in increasing k, then 0x00 for every padding and read byte.
- R9: MISO is sampled at each SCK rise. Read byte k, the (1+wr+pad+k)-th byte on the wire counting from 0, is returned in `rd_data_o[8k+7:8k]`, assembled MSB first. Slots at or beyond rd are zero, and the vector is cleared when a request is accepted.
- R10: `ack_o` is 1 exactly in a cycle where `req_i` is 1 and the block is free. `done_o` is a one-cycle pulse in the first cycle `nss_o` is high again, and `rd_data_o` is valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 1 | Request to start an exchange |
| req_opcode_i | input | 8 | Opcode byte sent first |
| req_wr_len_i | input | clog2(WR_MAX+1) | Number of write bytes |
| req_pad_len_i | input | clog2(PAD_MAX+1) | Number of filler bytes before read data |
| req_rd_len_i | input | clog2(RD_MAX+1) | Number of read bytes |
| req_wr_data_i | input | WR_MAX*8 | Write bytes, byte k at bits 8k+7:8k |
| ack_o | output | 1 | Request accepted this cycle |
| busy_o | output | 1 | Exchange or recovery interval in progress |
| done_o | output | 1 | One-cycle completion strobe |
| rd_data_o | output | RD_MAX*8 | Read bytes, byte k at bits 8k+7:8k |
| nss_o | output | 1 | Chip select, active low |
| sck_o | output | 1 | Serial clock, idle low |
| mosi_o | output | 1 | Serial data to peripheral |
| miso_i | input | 1 | Serial data from peripheral |

## Verification
The bench builds the block with HALF_DIV=2, LEAD_CYC=5, GAP_CYC=3, TRAIL_CYC=4, IDLE_CYC=6, WR_MAX=4, PAD_MAX=2 and RD_MAX=4. The intervals then differ from each other and from the half period, so an interval taken from the wrong counter load shows on the cycle-exact compare. The short lengths let a single exchange fill every write slot and every read slot, and also run an opcode-only exchange. A request held during a whole exchange plus its recovery interval shows the refusal window ending on the correct cycle.

// File: rtl/spim_pkg.sv
// Shared types of the guarded SPI command master.
// Assumes nothing beyond a single system clock domain.
package spim_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,   // NSS high, free
        ST_LEAD,   // NSS low, waiting before first clock
        ST_LOW,    // SCK low phase of a bit
        ST_HIGH,   // SCK high phase of a bit
        ST_GAP,    // pause between bytes
        ST_TRAIL,  // NSS low after final byte
        ST_COOL    // NSS high recovery, still busy
    } spim_state_t;
endpackage

// File: rtl/spim_count.sv
// Loadable down-counter that times every phase of the exchange.
// Assumes the owner reloads it on each phase entry with duration-1.
module spim_count #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    // Load a new duration or count down to zero and hold
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (load)           cnt_q <= load_val;
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/spim_byte_sel.sv
// Picks the byte to send for a given position in the exchange:
// the opcode at position 0, write bytes next, zero filler after.
// Assumes idx never exceeds the exchange length.
module spim_byte_sel #(
    parameter int WR_MAX = 4,
    parameter int IW     = 4,
    parameter int WLW    = 3
) (
    input  logic [IW-1:0]       idx,
    input  logic [7:0]          opcode,
    input  logic [WLW-1:0]      wr_len,
    input  logic [WR_MAX*8-1:0] wr_data,
    output logic [7:0]          byte_o
);
    // Mux opcode, one of the write slots, or filler
    always_comb begin
        byte_o = 8'h00;
        if (idx == '0) begin
            byte_o = opcode;
        end else begin
            for (int k = 0; k < WR_MAX; k++) begin
                if (idx == IW'(k + 1) && WLW'(k) < wr_len)
                    byte_o = wr_data[k*8 +: 8];
            end
        end
    end
endmodule

// File: rtl/spim_shift.sv
// Mode-0 byte shifter: transmit register drives MOSI from its MSB,
// receive register takes MISO in at each rising SCK.
// Assumes load, shift and sample are mutually exclusive strobes.
module spim_shift (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [7:0] load_byte,
    input  logic       shift,
    input  logic       sample,
    input  logic       miso,
    output logic       mosi,
    output logic [7:0] rx_byte
);
    logic [7:0] tx_q;
    logic [7:0] rx_q;

    // Transmit register: load a byte, move to the next bit on demand
    always_ff @(posedge clk) begin
        if (!rst_n)     tx_q <= '0;
        else if (load)  tx_q <= load_byte;
        else if (shift) tx_q <= {tx_q[6:0], 1'b0};
    end

    // Receive register: assemble MSB first
    always_ff @(posedge clk) begin
        if (!rst_n)      rx_q <= '0;
        else if (sample) rx_q <= {rx_q[6:0], miso};
    end

    assign mosi    = tx_q[7];
    assign rx_byte = rx_q;
endmodule

// File: rtl/spi_guard_master.sv
// SPI mode-0 command master with guard intervals around chip select
// and between bytes, for a firmware-serviced peripheral.
// Assumes all interval parameters are at least 1 and that request
// fields stay within their MAX parameters.
module spi_guard_master #(
    parameter int HALF_DIV  = 200,
    parameter int LEAD_CYC  = 3250,
    parameter int GAP_CYC   = 2000,
    parameter int TRAIL_CYC = 5000,
    parameter int IDLE_CYC  = 2500,
    parameter int WR_MAX    = 12,
    parameter int PAD_MAX   = 2,
    parameter int RD_MAX    = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_i,
    input  logic [7:0]                    req_opcode_i,
    input  logic [$clog2(WR_MAX+1)-1:0]   req_wr_len_i,
    input  logic [$clog2(PAD_MAX+1)-1:0]  req_pad_len_i,
    input  logic [$clog2(RD_MAX+1)-1:0]   req_rd_len_i,
    input  logic [WR_MAX*8-1:0]           req_wr_data_i,
    output logic                          ack_o,
    output logic                          busy_o,
    output logic                          done_o,
    output logic [RD_MAX*8-1:0]           rd_data_o,
    output logic                          nss_o,
    output logic                          sck_o,
    output logic                          mosi_o,
    input  logic                          miso_i
);
    import spim_pkg::*;

    localparam int WLW  = $clog2(WR_MAX+1);
    localparam int PLW  = $clog2(PAD_MAX+1);
    localparam int RLW  = $clog2(RD_MAX+1);
    localparam int IW   = $clog2(WR_MAX+PAD_MAX+RD_MAX+2);
    localparam int M1   = (HALF_DIV > LEAD_CYC) ? HALF_DIV : LEAD_CYC;
    localparam int M2   = (GAP_CYC > TRAIL_CYC) ? GAP_CYC : TRAIL_CYC;
    localparam int M3   = (M1 > M2) ? M1 : M2;
    localparam int DMAX = (M3 > IDLE_CYC) ? M3 : IDLE_CYC;
    localparam int CW   = $clog2(DMAX+1);

    spim_state_t st_q, st_n;
    logic [7:0]          opc_q;
    logic [WLW-1:0]      wr_len_q;
    logic [WR_MAX*8-1:0] wr_data_q;
    logic [IW-1:0]       last_q, rd_base_q, byte_q;
    logic [2:0]          bit_q;
    logic [RD_MAX*8-1:0] rd_q;
    logic                done_q;

    logic          accept, cnt_zero, cnt_load;
    logic [CW-1:0] cnt_val;
    logic          sr_load, sr_shift, sr_sample, byte_end;
    logic [7:0]    tx_byte, rx_byte;
    logic [IW-1:0] rd_slot;

    assign accept  = req_i && (st_q == ST_IDLE);
    assign rd_slot = byte_q - rd_base_q;

    spim_count #(.W(CW)) u_count (
        .clk(clk), .rst_n(rst_n), .load(cnt_load),
        .load_val(cnt_val), .zero(cnt_zero)
    );

    spim_byte_sel #(.WR_MAX(WR_MAX), .IW(IW), .WLW(WLW)) u_sel (
        .idx(byte_q), .opcode(opc_q), .wr_len(wr_len_q),
        .wr_data(wr_data_q), .byte_o(tx_byte)
    );

    spim_shift u_shift (
        .clk(clk), .rst_n(rst_n), .load(sr_load), .load_byte(tx_byte),
        .shift(sr_shift), .sample(sr_sample), .miso(miso_i),
        .mosi(mosi_o), .rx_byte(rx_byte)
    );

    // Phase sequencing and the duration loaded for each new phase
    always_comb begin
        st_n      = st_q;
        cnt_load  = 1'b0;
        cnt_val   = '0;
        sr_load   = 1'b0;
        sr_shift  = 1'b0;
        sr_sample = 1'b0;
        byte_end  = 1'b0;
        case (st_q)
            ST_IDLE: if (accept) begin
                st_n = ST_LEAD; cnt_load = 1'b1; cnt_val = CW'(LEAD_CYC-1);
            end
            ST_LEAD, ST_GAP: if (cnt_zero) begin
                st_n = ST_LOW; cnt_load = 1'b1; cnt_val = CW'(HALF_DIV-1);
                sr_load = 1'b1;
            end
            ST_LOW: if (cnt_zero) begin
                st_n = ST_HIGH; cnt_load = 1'b1; cnt_val = CW'(HALF_DIV-1);
                sr_sample = 1'b1;
            end
            ST_HIGH: if (cnt_zero) begin
                cnt_load = 1'b1;
                if (bit_q != 3'd7) begin
                    st_n = ST_LOW; cnt_val = CW'(HALF_DIV-1); sr_shift = 1'b1;
                end else if (byte_q == last_q) begin
                    st_n = ST_TRAIL; cnt_val = CW'(TRAIL_CYC-1); byte_end = 1'b1;
                end else begin
                    st_n = ST_GAP; cnt_val = CW'(GAP_CYC-1); byte_end = 1'b1;
                end
            end
            ST_TRAIL: if (cnt_zero) begin
                st_n = ST_COOL; cnt_load = 1'b1; cnt_val = CW'(IDLE_CYC-1);
            end
            ST_COOL: if (cnt_zero) st_n = ST_IDLE;
            default: st_n = ST_IDLE;
        endcase
    end

    // State register and completion strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            done_q <= 1'b0;
        end else begin
            st_q   <= st_n;
            done_q <= (st_q == ST_TRAIL) && cnt_zero;
        end
    end

    // Capture the request fields and derived byte positions on accept
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            opc_q     <= '0;
            wr_len_q  <= '0;
            wr_data_q <= '0;
            last_q    <= '0;
            rd_base_q <= '0;
        end else if (accept) begin
            opc_q     <= req_opcode_i;
            wr_len_q  <= req_wr_len_i;
            wr_data_q <= req_wr_data_i;
            last_q    <= IW'(req_wr_len_i) + IW'(req_pad_len_i) + IW'(req_rd_len_i);
            rd_base_q <= IW'(req_wr_len_i) + IW'(req_pad_len_i) + IW'(1);
        end
    end

    // Byte and bit position within the exchange
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_q <= '0;
            bit_q  <= '0;
        end else begin
            if (accept)        byte_q <= '0;
            else if (byte_end) byte_q <= byte_q + 1'b1;
            if (sr_load)       bit_q <= '0;
            else if (sr_shift) bit_q <= bit_q + 1'b1;
        end
    end

    // Store each completed read byte into its slot
    always_ff @(posedge clk) begin
        if (!rst_n || accept) begin
            rd_q <= '0;
        end else if (byte_end && byte_q >= rd_base_q) begin
            for (int k = 0; k < RD_MAX; k++)
                if (rd_slot == IW'(k)) rd_q[k*8 +: 8] <= rx_byte;
        end
    end

    assign ack_o     = accept;
    assign busy_o    = (st_q != ST_IDLE);
    assign done_o    = done_q;
    assign rd_data_o = rd_q;
    assign nss_o     = (st_q == ST_IDLE) || (st_q == ST_COOL);
    assign sck_o     = (st_q == ST_HIGH);
endmodule

// File: rtl/spim_checker.sv
// Port-level properties of the guarded SPI master, bound to the top.
// Assumes the same HALF_DIV and LEAD_CYC as the bound instance.
module spim_checker #(
    parameter int HALF_DIV = 2,
    parameter int LEAD_CYC = 5
) (
    input logic clk,
    input logic rst_n,
    input logic nss_o,
    input logic sck_o,
    input logic mosi_o,
    input logic busy_o,
    input logic ack_o,
    input logic done_o
);
    int  hi_cnt;
    int  lead_cnt;
    logic seen_sck;

    // Length of the current SCK high phase
    always_ff @(posedge clk) begin
        if (!rst_n)     hi_cnt <= 0;
        else if (sck_o) hi_cnt <= hi_cnt + 1;
        else            hi_cnt <= 0;
    end

    // Cycles since NSS fell, until the first SCK rise
    always_ff @(posedge clk) begin
        if (!rst_n || nss_o) begin
            lead_cnt <= 0;
            seen_sck <= 1'b0;
        end else begin
            if (lead_cnt < LEAD_CYC + HALF_DIV + 1) lead_cnt <= lead_cnt + 1;
            if (sck_o) seen_sck <= 1'b1;
        end
    end

    // R2
    sck_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sck_o |-> !nss_o);
    // R2
    mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sck_o && $past(sck_o)) |-> $stable(mosi_o));
    // R3
    sck_high_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sck_o && hi_cnt != 0) |-> (hi_cnt == HALF_DIV));
    // R4
    lead_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sck_o && !seen_sck) |-> (lead_cnt >= LEAD_CYC));
    // R7
    accept_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |=> (busy_o && !nss_o));
    // R7
    free_after_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> nss_o);
    // R10
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R10
    done_at_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $rose(nss_o));
endmodule

bind spi_guard_master spim_checker #(
    .HALF_DIV(HALF_DIV), .LEAD_CYC(LEAD_CYC)
) u_chk (
    .clk(clk), .rst_n(rst_n), .nss_o(nss_o), .sck_o(sck_o),
    .mosi_o(mosi_o), .busy_o(busy_o), .ack_o(ack_o), .done_o(done_o)
);

// File: tb/spi_guard_master_bench.sv
`timescale 1ns/1ps
module spi_guard_master_bench;
    localparam int HALF = 2, LEAD = 5, GAP = 3, TRAIL = 4, IDLE = 6;
    localparam int WRM = 4, PADM = 2, RDM = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req = 1'b0;
    logic [7:0] opc = '0;
    logic [2:0] wr_len = '0;
    logic [1:0] pad_len = '0;
    logic [2:0] rd_len = '0;
    logic [WRM*8-1:0] wdata = '0;
    logic ack_o, busy_o, done_o, nss_o, sck_o, mosi_o;
    logic miso = 1'b0;
    logic [RDM*8-1:0] rd_data_o;

    int checks = 0, fails = 0;
    int cycles = 0;
    logic cur_busy = 1'b0;
    logic [RDM*8-1:0] exp_rd = '0;
    logic [7:0] seed = 8'h00;

    // phase: 0 idle, 1 lead, 2 bit, 3 gap, 4 trail, 5 recovery
    typedef struct packed {
        logic [2:0] ph;
        logic nss, sck, mosi, mchk, busy, done, miso;
    } exp_t;
    exp_t q[$];

    always #2.5 clk = ~clk;

    spi_guard_master #(
        .HALF_DIV(HALF), .LEAD_CYC(LEAD), .GAP_CYC(GAP), .TRAIL_CYC(TRAIL),
        .IDLE_CYC(IDLE), .WR_MAX(WRM), .PAD_MAX(PADM), .RD_MAX(RDM)
    ) u_spi_guard_master (
        .clk(clk), .rst_n(rst_n), .req_i(req), .req_opcode_i(opc),
        .req_wr_len_i(wr_len), .req_pad_len_i(pad_len), .req_rd_len_i(rd_len),
        .req_wr_data_i(wdata), .ack_o(ack_o), .busy_o(busy_o), .done_o(done_o),
        .rd_data_o(rd_data_o), .nss_o(nss_o), .sck_o(sck_o), .mosi_o(mosi_o),
        .miso_i(miso)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h at cycle %0d",
                     tag, what, act, exp, cycles);
        end
    endtask

    function automatic string ph_tag(input logic [2:0] ph);
        case (ph)
            3'd1: return "R4";
            3'd2: return "R3";
            3'd3: return "R5";
            3'd4: return "R6";
            3'd5: return "R7";
            default: return "R1";
        endcase
    endfunction

    function automatic logic [7:0] resp_of(input int i);
        return 8'h3C ^ (8'(i) * 8'h29) ^ seed;
    endfunction

    // Reference model: one expected entry per cycle, compared every clock
    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            exp_t e;
            string t;
            if (q.size() > 0) e = q.pop_front();
            else e = '{ph:3'd0, nss:1'b1, sck:1'b0, mosi:1'b0, mchk:1'b0,
                       busy:1'b0, done:1'b0, miso:1'b0};
            miso = e.miso;
            cur_busy = e.busy;
            t = ph_tag(e.ph);
            chk(nss_o == e.nss, t, "nss", nss_o, e.nss);
            chk(sck_o == e.sck, (e.ph == 3'd2) ? "R3" : "R2", "sck", sck_o, e.sck);
            chk(busy_o == e.busy, "R7", "busy", busy_o, e.busy);
            chk(done_o == e.done, "R10", "done", done_o, e.done);
            if (e.mchk) chk(mosi_o == e.mosi, "R8", "mosi", mosi_o, e.mosi);
            if (e.done) chk(rd_data_o == exp_rd, "R9", "rd_data", rd_data_o, exp_rd);
        end
    end

    task automatic push(input logic [2:0] ph, input int n, input logic nss,
                        input logic sck, input logic mosi, input logic mchk,
                        input logic busy, input logic dn, input logic mi);
        for (int i = 0; i < n; i++)
            q.push_back('{ph:ph, nss:nss, sck:sck, mosi:mosi, mchk:mchk,
                          busy:busy, done:(dn && i == 0), miso:mi});
    endtask

    // Issue a request, hold it while refused, then queue the expected frame
    task automatic send(input logic [7:0] o, input int wr, input int pad,
                        input int rd, input logic [WRM*8-1:0] wd, input logic [7:0] sd);
        int total;
        @(negedge clk);
        opc = o; wr_len = 3'(wr); pad_len = 2'(pad); rd_len = 3'(rd);
        wdata = wd; req = 1'b1;
        forever begin
            #1;
            // R7 refusal while busy, R10 acceptance when free
            chk(ack_o == !cur_busy, cur_busy ? "R7" : "R10", "ack", ack_o, !cur_busy);
            if (ack_o) break;
            @(negedge clk);
        end
        seed = sd;
        total = 1 + wr + pad + rd;
        exp_rd = '0;
        for (int k = 0; k < rd; k++) exp_rd[k*8 +: 8] = resp_of(1 + wr + pad + k);
        push(3'd1, LEAD, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        for (int b = 0; b < total; b++) begin
            logic [7:0] v;
            logic [7:0] r;
            v = (b == 0) ? o : (b <= wr) ? wd[(b-1)*8 +: 8] : 8'h00;
            r = resp_of(b);
            if (b > 0) push(3'd3, GAP, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
            for (int k = 7; k >= 0; k--) begin
                push(3'd2, HALF, 1'b0, 1'b0, v[k], 1'b1, 1'b1, 1'b0, r[k]);
                push(3'd2, HALF, 1'b0, 1'b1, v[k], 1'b1, 1'b1, 1'b0, r[k]);
            end
        end
        push(3'd4, TRAIL, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        push(3'd5, IDLE, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
        @(posedge clk);
        @(negedge clk);
        req = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset values
        chk(nss_o == 1'b1, "R1", "nss in reset", nss_o, 1);
        chk(sck_o == 1'b0, "R1", "sck in reset", sck_o, 0);
        chk(busy_o == 1'b0, "R1", "busy in reset", busy_o, 0);
        chk(done_o == 1'b0, "R1", "done in reset", done_o, 0);
        chk(rd_data_o == '0, "R1", "rd_data in reset", rd_data_o, 0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // opcode only
        send(8'h0A, 0, 0, 0, '0, 8'h11);
        wait (q.size() == 0);
        // opcode and write bytes, R8 ordering
        send(8'h07, 3, 0, 0, {8'h00, 8'h81, 8'h5A, 8'hC3}, 8'h22);
        wait (q.size() == 0);
        repeat (4) @(negedge clk);
        // padding then reads, R9 slot placement
        send(8'h04, 0, 1, 2, '0, 8'h5F);
        wait (q.size() == 0);
        // every slot filled, then a request held through the busy window
        send(8'h13, 4, 2, 4, {8'hF0, 8'h0F, 8'hA5, 8'h96}, 8'h9C);
        send(8'h06, 1, 0, 1, {24'h0, 8'h7E}, 8'h44);
        wait (q.size() == 0);
        repeat (5) @(negedge clk);
        chk(nss_o == 1'b1 && busy_o == 1'b0, "R7", "idle after all", {nss_o, busy_o}, 2'b10);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule